// File: doc/BRIEF.md
# Supervisory Reset and Chip-Enable Gate

This block drives an active-low processor reset and a gated active-low chip-enable for memory. Reset comes from two causes: a flag from an external comparator that reports the supply below the reset threshold, and an active-low manual-reset pin. The pin is synchronised and debounced on board. When the last cause clears, reset is held for a fixed number of time-base ticks before it releases. A second comparator flag warns that the supply is close to the threshold. It is passed straight through to an active-low low-line output and has no effect on reset.

The chip-enable gate passes the chip-enable input through while reset is released. When reset asserts, the gate blocks new accesses. An access that is already in progress, because the input is low at that moment, is kept alive for a bounded grace time or until the input goes high, whichever comes first. After that the output stays high until reset releases. All durations are counted on a single-cycle `tick` strobe, so the real timing is set by the tick rate together with the tick-count parameters.

Top module: `sup_reset_gate`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it releases, `reset_n_o` is 0 and `ce_n_o` is 1. Reset is asserted from power-on.
- R2: While `supply_low_i` is 1, `reset_n_o` is 0 from the first clock edge after the flag is sampled high.
- R3: Once no cause is active, `reset_n_o` rises at the clock edge that samples the HOLD_TICKS-th `tick` counted from the first edge with no cause.
- R4: `mr_n_i` passes two synchroniser flops. A new level is accepted only after DEB_TICKS ticks at which the synchronised level differed from the accepted one, with no edge in between where they agreed. Shorter pulses do not affect `reset_n_o`.
- R5: An accepted low on `mr_n_i` is a reset cause just like `supply_low_i`: reset is held low while it lasts and released through the R3 hold-off after the accepted release.
- R6: A cause that arrives during the hold-off restarts the count from zero.
- R7: `lowline_n_o` is the inverse of `lowline_warn_i` at all times, whatever the reset state.
- R8: While reset has been released for at least one edge, `ce_n_o` equals `ce_n_i`.
- R9: If `ce_n_i` is 1 when reset asserts, `ce_n_o` is 1 until reset releases, even if `ce_n_i` later falls.
- R10: If `ce_n_i` is 0 when reset asserts, `ce_n_o` follows `ce_n_i` for at most GRACE_TICKS ticks. The grace time ends at the first `ce_n_i` high or at the GRACE_TICKS-th tick, and from then on `ce_n_o` is 1 until reset releases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tick | input | 1 | Time-base strobe, one cycle wide |
| supply_low_i | input | 1 | 1 while the supply is below the reset threshold |
| lowline_warn_i | input | 1 | 1 while the supply is near the reset threshold |
| mr_n_i | input | 1 | Asynchronous active-low manual reset |
| ce_n_i | input | 1 | Active-low chip-enable request |
| reset_n_o | output | 1 | Active-low processor reset |
| lowline_n_o | output | 1 | Active-low low-line warning |
| ce_n_o | output | 1 | Gated active-low chip-enable |

## Verification
Directed cases first measure the exact hold-off length after power-on, after a supply dip and after a dip that interrupts a running hold-off. A restart that was missed shows up as an early release. Manual-reset pulses just short of and well above the debounce length separate filtered glitches from accepted presses. Chip-enable cases assert reset with the input high, with the input low held past the grace time, and with the input rising early. These cases tell blocking apart from grace, and grace expiry apart from early exit. A long random phase with irregular ticks and random levels on every input is then compared cycle by cycle with a reference model in the bench.

// File: rtl/sup_reset_pkg.sv
package sup_reset_pkg;
  typedef enum logic [1:0] {
    CE_PASS  = 2'd0,
    CE_GRACE = 2'd1,
    CE_BLOCK = 2'd2
  } ce_state_e;
endpackage

// File: rtl/mr_conditioner.sv
module mr_conditioner #(
  parameter int unsigned DEB_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic mr_n_i,
  output logic mr_active_o
);
  localparam int unsigned CW = $clog2(DEB_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

  logic          sync1_q, sync2_q;
  logic          deb_q, deb_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    deb_d = deb_q;
    cnt_d = cnt_q;
    if (sync2_q == deb_q) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q == LAST) begin
        deb_d = sync2_q;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      deb_q   <= 1'b1;
      cnt_q   <= '0;
    end else begin
      sync1_q <= mr_n_i;
      sync2_q <= sync1_q;
      deb_q   <= deb_d;
      cnt_q   <= cnt_d;
    end
  end

  assign mr_active_o = ~deb_q;

  // R4: the accepted level only moves on a tick edge
  a_r4_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (deb_q != $past(deb_q)) |-> $past(tick));
  // R4: the accepted level only moves toward the synchronised level
  a_r4_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (deb_q != $past(deb_q)) |-> (deb_q == $past(sync2_q)));
endmodule

// File: rtl/reset_holdoff.sv
module reset_holdoff #(
  parameter int unsigned HOLD_TICKS = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cause_i,
  output logic reset_n_o
);
  localparam int unsigned CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic          out_q, out_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    out_d = out_q;
    cnt_d = cnt_q;
    if (cause_i) begin
      out_d = 1'b0;
      cnt_d = '0;
    end else if (!out_q && tick) begin
      if (cnt_q == LAST) begin
        out_d = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      out_q <= out_d;
      cnt_q <= cnt_d;
    end
  end

  assign reset_n_o = out_q;

  // R2 / R5: an active cause pulls reset low at the next edge
  a_r2_cause_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    cause_i |=> !reset_n_o);
  // R3 / R6: release only on a tick with no cause present
  a_r3_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_n_o) |-> ($past(tick) && !$past(cause_i)));
  // R6: a restarted count is not complete on the next tick
  a_r6_no_release_after_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cause_i |=> !$rose(reset_n_o));
endmodule

// File: rtl/ce_gate.sv
module ce_gate
  import sup_reset_pkg::*;
#(
  parameter int unsigned GRACE_TICKS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic reset_n_i,
  input  logic ce_n_i,
  output logic ce_n_o
);
  localparam int unsigned CW = $clog2(GRACE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(GRACE_TICKS - 1);

  ce_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rst_act;

  assign rst_act = ~reset_n_i;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      CE_PASS: begin
        if (rst_act) begin
          st_d  = ce_n_i ? CE_BLOCK : CE_GRACE;
          cnt_d = '0;
        end
      end
      CE_GRACE: begin
        if (!rst_act) begin
          st_d = CE_PASS;
        end else if (ce_n_i) begin
          st_d = CE_BLOCK;
        end else if (tick) begin
          if (cnt_q == LAST) begin
            st_d = CE_BLOCK;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        if (!rst_act) st_d = CE_PASS;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CE_BLOCK;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign ce_n_o = (st_q == CE_BLOCK) ? 1'b1 : ce_n_i;

  // R10: the output is never low without a low request
  a_r10_low_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n_o |-> !ce_n_i);
  // R8: pass-through once reset has been released for an edge
  a_r8_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_n_i && $past(reset_n_i)) |-> (ce_n_o == ce_n_i));
  // R9 / R10: once high during reset, stays high while reset lasts
  a_r9_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_act && $past(rst_act) && $past(ce_n_o)) |-> ce_n_o);
endmodule

// File: rtl/sup_reset_gate.sv
module sup_reset_gate #(
  parameter int unsigned HOLD_TICKS  = 200000,
  parameter int unsigned DEB_TICKS   = 4,
  parameter int unsigned GRACE_TICKS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic supply_low_i,
  input  logic lowline_warn_i,
  input  logic mr_n_i,
  input  logic ce_n_i,
  output logic reset_n_o,
  output logic lowline_n_o,
  output logic ce_n_o
);
  logic mr_active;
  logic cause;

  mr_conditioner #(.DEB_TICKS(DEB_TICKS)) u_mr (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .mr_n_i     (mr_n_i),
    .mr_active_o(mr_active)
  );

  assign cause = supply_low_i | mr_active;

  reset_holdoff #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cause_i  (cause),
    .reset_n_o(reset_n_o)
  );

  ce_gate #(.GRACE_TICKS(GRACE_TICKS)) u_ce (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .reset_n_i(reset_n_o),
    .ce_n_i   (ce_n_i),
    .ce_n_o   (ce_n_o)
  );

  assign lowline_n_o = ~lowline_warn_i;

  // R7: warning output tracks its flag with no reset dependence
  always_comb begin
    a_r7_lowline: assert (lowline_n_o !== lowline_warn_i);
  end
endmodule

// File: tb/sup_reset_gate_tb.sv
module sup_reset_gate_tb;
  localparam int HOLD  = 12;
  localparam int DEB   = 3;
  localparam int GRACE = 4;

  logic clk = 1'b0;
  logic rst_n, tick, supply_low_i, lowline_warn_i, mr_n_i, ce_n_i;
  logic reset_n_o, lowline_n_o, ce_n_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  string cur_tag = "R1";

  always #2 clk = ~clk;

  sup_reset_gate #(.HOLD_TICKS(HOLD), .DEB_TICKS(DEB), .GRACE_TICKS(GRACE)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_low_i(supply_low_i),
    .lowline_warn_i(lowline_warn_i), .mr_n_i(mr_n_i), .ce_n_i(ce_n_i),
    .reset_n_o(reset_n_o), .lowline_n_o(lowline_n_o), .ce_n_o(ce_n_o));

  // reference model, written from the requirements
  logic m_s1, m_s2, m_deb, m_rst;
  int   m_dcnt, m_hcnt, m_gcnt;
  int   m_st; // 0 pass, 1 grace, 2 block

  function automatic logic exp_ce(int st, logic cin);
    return (st == 2) ? 1'b1 : cin;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_deb = 1; m_dcnt = 0;
      m_rst = 0; m_hcnt = 0; m_st = 2; m_gcnt = 0;
    end else begin
      logic n_deb, n_rst, cause;
      int n_dcnt, n_hcnt, n_st, n_gcnt;
      n_deb = m_deb; n_dcnt = m_dcnt;
      if (m_s2 == m_deb) n_dcnt = 0;
      else if (tick) begin
        if (m_dcnt == DEB-1) begin n_deb = m_s2; n_dcnt = 0; end
        else n_dcnt = m_dcnt + 1;
      end
      cause = supply_low_i | ~m_deb;
      n_rst = m_rst; n_hcnt = m_hcnt;
      if (cause) begin n_rst = 0; n_hcnt = 0; end
      else if (!m_rst && tick) begin
        if (m_hcnt == HOLD-1) begin n_rst = 1; n_hcnt = 0; end
        else n_hcnt = m_hcnt + 1;
      end
      n_st = m_st; n_gcnt = m_gcnt;
      case (m_st)
        0: if (!m_rst) begin n_st = ce_n_i ? 2 : 1; n_gcnt = 0; end
        1: if (m_rst) n_st = 0;
           else if (ce_n_i) n_st = 2;
           else if (tick) begin
             if (m_gcnt == GRACE-1) n_st = 2; else n_gcnt = m_gcnt + 1;
           end
        default: if (m_rst) n_st = 0;
      endcase
      m_s2 = m_s1; m_s1 = mr_n_i;
      m_deb = n_deb; m_dcnt = n_dcnt;
      m_rst = n_rst; m_hcnt = n_hcnt;
      m_st = n_st; m_gcnt = n_gcnt;
    end
  end

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison against the model, before inputs move
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_tag, reset_n_o, m_rst);
      check("R7", lowline_n_o, ~lowline_warn_i);
      if (m_st == 0 && m_rst) check("R8", ce_n_o, ce_n_i);
      else if (m_st == 2)     check("R9", ce_n_o, exp_ce(m_st, ce_n_i));
      else                    check("R10", ce_n_o, exp_ce(m_st, ce_n_i));
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'd2024));
    rst_n = 0; tick = 1; supply_low_i = 0; lowline_warn_i = 0; mr_n_i = 1; ce_n_i = 1;
    step(3);
    check("R1", reset_n_o, 1'b0);
    check("R1", ce_n_o, 1'b1);
    rst_n = 1;
    step(1);
    check("R1", reset_n_o, 1'b0);
    check("R1", ce_n_o, 1'b1);
    // R3: power-on hold-off length, tick every cycle
    cur_tag = "R3";
    n = 1;
    while (!reset_n_o && n < 100) begin step(1); n++; end
    check("R3", n == HOLD, 1'b1);

    // R2 then R3 after a supply dip
    cur_tag = "R2";
    supply_low_i = 1; lowline_warn_i = 1; step(1);
    check("R2", reset_n_o, 1'b0);
    check("R7", lowline_n_o, 1'b0);
    step(3);
    supply_low_i = 0; cur_tag = "R3";
    step(HOLD - 1); check("R3", reset_n_o, 1'b0);
    step(1);        check("R3", reset_n_o, 1'b1);
    lowline_warn_i = 0;

    // R6: second cause during the hold-off restarts it
    cur_tag = "R6";
    supply_low_i = 1; step(2); supply_low_i = 0; step(5);
    supply_low_i = 1; step(1); supply_low_i = 0;
    step(HOLD - 1); check("R6", reset_n_o, 1'b0);
    step(1);        check("R6", reset_n_o, 1'b1);

    // R4: manual pulse shorter than the debounce is ignored
    cur_tag = "R4";
    mr_n_i = 0; step(DEB - 1); mr_n_i = 1;
    for (int i = 0; i < 8; i++) begin step(1); check("R4", reset_n_o, 1'b1); end

    // R5: long press asserts, release goes through debounce and hold-off
    cur_tag = "R5";
    mr_n_i = 0; step(10);
    check("R5", reset_n_o, 1'b0);
    mr_n_i = 1;
    step(HOLD); check("R5", reset_n_o, 1'b0);
    n = 0;
    while (!reset_n_o && n < 20) begin step(1); n++; end
    check("R5", reset_n_o, 1'b1);

    // R8: pass-through while reset is released
    ce_n_i = 0; step(1); check("R8", ce_n_o, 1'b0);
    ce_n_i = 1; step(1); check("R8", ce_n_o, 1'b1);

    // R10: access in progress runs out the grace time
    cur_tag = "R2";
    ce_n_i = 0; supply_low_i = 1;
    step(1 + GRACE); check("R10", ce_n_o, 1'b0);
    step(1);         check("R10", ce_n_o, 1'b1);
    step(3);         check("R10", ce_n_o, 1'b1);
    // R10: early end of access, no re-entry
    supply_low_i = 0; ce_n_i = 1; step(HOLD + 2);
    check("R8", reset_n_o, 1'b1);
    ce_n_i = 0; step(1);
    supply_low_i = 1; step(2);
    check("R10", ce_n_o, 1'b0);
    ce_n_i = 1; step(1); ce_n_i = 0; step(1);
    check("R10", ce_n_o, 1'b1);
    // R9: request arriving after reset asserts is blocked
    supply_low_i = 0; ce_n_i = 1; step(HOLD + 2);
    supply_low_i = 1; step(2); ce_n_i = 0; step(2);
    check("R9", ce_n_o, 1'b1);
    supply_low_i = 0; ce_n_i = 1; step(HOLD + 2);

    // random phase against the model
    cur_tag = "R5";
    for (int i = 0; i < 6000; i++) begin
      tick           = ($urandom % 3) == 0;
      supply_low_i   = ($urandom % 40) == 0 ? ~supply_low_i : supply_low_i;
      lowline_warn_i = ($urandom % 10) == 0 ? ~lowline_warn_i : lowline_warn_i;
      mr_n_i         = ($urandom % 25) == 0 ? ~mr_n_i : mr_n_i;
      ce_n_i         = ($urandom % 6) == 0 ? ~ce_n_i : ce_n_i;
      step(1);
    end
    finish_run();
  end
endmodule